// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds four independent pulse-width channels behind a small write/read register port. Software loads a period value and a compare value into each channel's buffer registers. It picks a per-channel tick divider and then drives the channels through one shared control word. Each channel runs a 16-bit down-counter. The counter loads from the buffers, counts one step per divided tick, and raises the channel's output once the value left after a decrement matches the compare value. When the counter expires, the output drops back to its inactive level.

The buffers move into the active counter and compare registers in two cases: while the channel's manual-update bit is held, or at expiry when auto-reload is enabled. New values can therefore be staged while a waveform runs and take effect at the next period boundary. A common input tick feeds every divider, so one external strobe sets the time base of the whole bank.

Top module: `pwm_bank`

## Requirements
- R1: After synchronous reset every mapped register reads zero, every `pwm_out` bit is low, and no channel counts until it is started.
- R2: Control word at address 0x0. Channel 0 owns bits 3:0 and channel n≥1 owns bits 4n+7:4n+4. Within each nibble the bits are: bit 0 start, bit 1 manual update, bit 2 invert, bit 3 auto-reload. Bits 7:4 and 31:20 ignore writes and read zero.
- R3: Address 0x1 holds the divider codes, two bits per channel at [2n+1:2n], where codes 0,1,2,3 select division by 2,4,8,16. Bits above 7 read zero. Address 0x2+2n holds channel n's count buffer and 0x3+2n its compare buffer; each keeps the low 16 data bits and reads zero above them. Writes to addresses 0xA–0xF have no effect, and those addresses read zero.
- R4: With auto-reload on and compare value M below count value C, the waveform repeats every C+1 channel ticks and stays active for M+1 of them.
- R5: A channel tick occurs once per D input ticks, where D is the divider selected for that channel. With `tick_in` held high, one period therefore lasts (C+1)·D clock cycles.
- R6: The compare match is tested only on the value left after a decrement, so with M ≥ C the output never goes active.
- R7: While a channel's start bit is clear, its counter is frozen and its output pin holds its level.
- R8: While a channel's manual-update bit is set, the buffers are copied into the active registers every cycle, the counter does not run, and the output sits at its inactive level.
- R9: Without auto-reload, a started channel produces exactly one active pulse and then stays inactive.
- R10: Buffer values written while a channel runs take effect at the next expiry, without a manual update.
- R11: The invert bit flips the pin, so the active level becomes low and the inactive level high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| tick_in | input | 1 | Common input tick strobe shared by all dividers |
| pwm_out | output | 4 | One PWM pin per channel |

## Verification
A register write lands on the clock edge where `wr_en` is sampled, and `rd_data` shows the new value in the cycle after that edge. A channel acts on a new control word one edge later again, so its pin can first change two edges after the write. The bench drives inputs and samples outputs on the falling edge. Before it checks a pin level, it waits out that extra edge. Waveform checks use durations instead of absolute times: the bench waits for a pin transition, then counts the falling-edge samples spent at the active and inactive levels and compares them with (M+1)·D and (C−M)·D. This makes the result independent of the phase at which a channel started.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int DSEL_W = 2;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_DIV  = 1;
    localparam int ADDR_BUF0 = 2;

    // one control nibble; packed so that bit 0 is start, bit 3 auto-reload
    typedef struct packed {
        logic reload;
        logic invert;
        logic manual;
        logic start;
    } chan_ctrl_t;

    localparam int CTRL_NIB_W = $bits(chan_ctrl_t);

    // lowest bit of a channel's nibble inside the shared control word
    function automatic int ctrl_lsb(int ch);
        return (ch == 0) ? 0 : (CTRL_NIB_W * ch + CTRL_NIB_W);
    endfunction

    function automatic int cnt_addr(int ch);
        return ADDR_BUF0 + 2 * ch;
    endfunction

    function automatic int cmp_addr(int ch);
        return ADDR_BUF0 + 2 * ch + 1;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CNT_W,
    parameter int A_W  = ADDR_W,
    parameter int D_W  = DATA_W,
    parameter int S_W  = DSEL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [A_W-1:0]             wr_addr,
    input  logic [D_W-1:0]             wr_data,
    input  logic [A_W-1:0]             rd_addr,
    output logic [D_W-1:0]             rd_data,
    output chan_ctrl_t [N_CH-1:0]      ctrl,
    output logic [N_CH-1:0][S_W-1:0]   dsel,
    output logic [N_CH-1:0][C_W-1:0]   cnt_buf,
    output logic [N_CH-1:0][C_W-1:0]   cmp_buf
);

    localparam int DIV_BITS = N_CH * S_W;

    chan_ctrl_t [N_CH-1:0]    ctrl_q;
    logic [N_CH-1:0][S_W-1:0] dsel_q;
    logic [D_W-1:0]           ctrl_img;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dsel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_W'(ADDR_CTRL)) begin
                for (int ch = 0; ch < N_CH; ch++) begin
                    ctrl_q[ch] <= wr_data[ctrl_lsb(ch) +: CTRL_NIB_W];
                end
            end
            if (wr_addr == A_W'(ADDR_DIV)) begin
                dsel_q <= wr_data[DIV_BITS-1:0];
            end
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_buf
        logic [C_W-1:0] cnt_q;
        logic [C_W-1:0] cmp_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                cmp_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_W'(cnt_addr(g))) cnt_q <= wr_data[C_W-1:0];
                if (wr_addr == A_W'(cmp_addr(g))) cmp_q <= wr_data[C_W-1:0];
            end
        end

        assign cnt_buf[g] = cnt_q;
        assign cmp_buf[g] = cmp_q;
    end

    always_comb begin
        ctrl_img = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            ctrl_img[ctrl_lsb(ch) +: CTRL_NIB_W] = ctrl_q[ch];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_W'(ADDR_CTRL)) rd_data = ctrl_img;
        if (rd_addr == A_W'(ADDR_DIV))  rd_data = D_W'(dsel_q);
        for (int ch = 0; ch < N_CH; ch++) begin
            if (rd_addr == A_W'(cnt_addr(ch))) rd_data = D_W'(cnt_buf[ch]);
            if (rd_addr == A_W'(cmp_addr(ch))) rd_data = D_W'(cmp_buf[ch]);
        end
    end

    assign ctrl = ctrl_q;
    assign dsel = dsel_q;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int S_W = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           tick_in,
    input  logic [S_W-1:0] sel,
    output logic           tick
);

    // largest ratio is 2 << (2^S_W - 1), so the count needs 2^S_W bits
    localparam int PRE_W = 1 << S_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   ratio;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    assign ratio    = (PRE_W + 1)'(2) << sel;
    assign limit    = PRE_W'(ratio - (PRE_W + 1)'(1));
    assign at_limit = (pre_q >= limit);
    assign tick     = run & tick_in & at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (tick_in) begin
            pre_q <= at_limit ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  chan_ctrl_t     ctrl,
    input  logic           tick,
    input  logic [C_W-1:0] cnt_buf,
    input  logic [C_W-1:0] cmp_buf,
    output logic           pin
);

    logic [C_W-1:0] cnt_q;
    logic [C_W-1:0] cmp_q;
    logic           lvl_q;
    logic [C_W-1:0] cnt_dec;
    logic           expired;

    assign cnt_dec = cnt_q - 1'b1;
    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cmp_q <= '0;
            lvl_q <= 1'b0;
        end else if (ctrl.manual) begin
            cnt_q <= cnt_buf;
            cmp_q <= cmp_buf;
            lvl_q <= 1'b0;
        end else if (tick) begin
            if (expired) begin
                lvl_q <= 1'b0;
                if (ctrl.reload) begin
                    cnt_q <= cnt_buf;
                    cmp_q <= cmp_buf;
                end
            end else begin
                cnt_q <= cnt_dec;
                if (cnt_dec == cmp_q) lvl_q <= 1'b1;
            end
        end
    end

    assign pin = lvl_q ^ ctrl.invert;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CNT_W,
    parameter int A_W  = ADDR_W,
    parameter int D_W  = DATA_W,
    parameter int S_W  = DSEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [A_W-1:0]  wr_addr,
    input  logic [D_W-1:0]  wr_data,
    input  logic [A_W-1:0]  rd_addr,
    output logic [D_W-1:0]  rd_data,
    input  logic            tick_in,
    output logic [N_CH-1:0] pwm_out
);

    chan_ctrl_t [N_CH-1:0]    ctrl_q;
    logic [N_CH-1:0][S_W-1:0] dsel;
    logic [N_CH-1:0][C_W-1:0] cnt_buf;
    logic [N_CH-1:0][C_W-1:0] cmp_buf;

    pwm_regs #(
        .N_CH(N_CH), .C_W(C_W), .A_W(A_W), .D_W(D_W), .S_W(S_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl    (ctrl_q),
        .dsel    (dsel),
        .cnt_buf (cnt_buf),
        .cmp_buf (cmp_buf)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic run;
        logic ch_tick;

        assign run = ctrl_q[g].start & ~ctrl_q[g].manual;

        pwm_prescaler #(.S_W(S_W)) u_pre (
            .clk     (clk),
            .rst     (rst),
            .run     (run),
            .tick_in (tick_in),
            .sel     (dsel[g]),
            .tick    (ch_tick)
        );

        pwm_channel #(.C_W(C_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl_q[g]),
            .tick    (ch_tick),
            .cnt_buf (cnt_buf[g]),
            .cmp_buf (cmp_buf[g]),
            .pin     (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int A_W  = ADDR_W,
    parameter int D_W  = DATA_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [A_W-1:0]        rd_addr,
    input logic [D_W-1:0]        rd_data,
    input logic [N_CH-1:0]       pwm_out,
    input chan_ctrl_t [N_CH-1:0] ctrl
);

    localparam int LAST_ADDR = cmp_addr(N_CH - 1);

    // R1: the edge after a reset cycle leaves every pin low
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> (pwm_out == '0));

    // R2: unowned control bits always read back as zero
    assert_ctrl_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_W'(ADDR_CTRL)) |-> (rd_data[7:4] == 4'h0 && rd_data[D_W-1:20] == '0));

    // R3: addresses past the last buffer read zero
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) > LAST_ADDR) |-> (rd_data == '0));

    // R3: buffer reads never carry bits above the counter width
    assert_buf_width_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= ADDR_BUF0 && int'(rd_addr) <= LAST_ADDR) |-> (rd_data[D_W-1:CNT_W] == '0));

    for (genvar g = 0; g < N_CH; g++) begin : g_chan_chk
        // R7: a stopped channel with unchanged control keeps its pin level
        assert_halt_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (ctrl[g] == $past(ctrl[g]) && !ctrl[g].start && !ctrl[g].manual)
            |-> $stable(pwm_out[g]));

        // R8: holding manual update parks the pin at its inactive level
        assert_manual_idle_R8: assert property (@(posedge clk) disable iff (rst)
            ($past(ctrl[g].manual) && ctrl[g] == $past(ctrl[g]))
            |-> (pwm_out[g] == ctrl[g].invert));
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .N_CH(N_CH), .A_W(A_W), .D_W(D_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .ctrl    (ctrl_q)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick_in = 1'b1;
    logic [3:0]  pwm_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    pwm_bank i_pwm_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tick_in (tick_in),
        .pwm_out (pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // wait for a transition into the active level, then count clocks active/inactive
    task automatic measure(int ch, logic act_lvl, output int hi, output int lo);
        int guard = 0;
        @(negedge clk);
        while (pwm_out[ch] == act_lvl && guard < 4000) begin @(negedge clk); guard++; end
        while (pwm_out[ch] != act_lvl && guard < 4000) begin @(negedge clk); guard++; end
        hi = 0;
        while (pwm_out[ch] == act_lvl && hi < 4000) begin hi++; @(negedge clk); end
        lo = 0;
        while (pwm_out[ch] != act_lvl && lo < 4000) begin lo++; @(negedge clk); end
    endtask

    task automatic load_ch(int ch, logic [1:0] code_unused, int cnt, int cmp);
        wr(4'(2 + 2 * ch), 32'(cnt));
        wr(4'(3 + 2 * ch), 32'(cmp));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check($sformatf("R1 addr %0d", a), d, 32'h0);
        end
        check("R1 pins", 32'(pwm_out), 32'h0);
        repeat (20) @(negedge clk);
        check("R1 idle pins", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d);
        check("R2 control layout", d, 32'h000F_FF0F);
        wr(4'h0, 32'h0000_0000);
        wr(4'h1, 32'hFFFF_FFFF);
        rd(4'h1, d);
        check("R3 divider width", d, 32'h0000_00FF);
        wr(4'h1, 32'h0);
        wr(4'h2, 32'hABCD_1234);
        rd(4'h2, d);
        check("R3 count buffer", d, 32'h0000_1234);
        wr(4'h9, 32'h5555_BEEF);
        rd(4'h9, d);
        check("R3 last compare buffer", d, 32'h0000_BEEF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d);
        check("R3 unmapped read", d, 32'h0);
        for (int a = 2; a < 10; a++) begin
            if (a != 2 && a != 9) begin
                rd(4'(a), d);
                check("R3 unmapped write ignored", d, 32'h0);
            end
        end
    endtask

    task automatic t_basic();
        int hi, lo;
        wr(4'h1, 32'h0);
        load_ch(0, 2'd0, 9, 3);
        wr(4'h0, 32'h0000_000A);
        wr(4'h0, 32'h0000_0009);
        measure(0, 1'b1, hi, lo);
        check("R4 active clocks div2", 32'(hi), 32'd8);
        check("R4 inactive clocks div2", 32'(lo), 32'd12);
    endtask

    task automatic t_div16();
        int hi, lo;
        wr(4'h1, 32'h0000_000C);
        load_ch(1, 2'd3, 3, 1);
        wr(4'h0, 32'h0000_0A00);
        wr(4'h0, 32'h0000_0900);
        measure(1, 1'b1, hi, lo);
        check("R5 active clocks div16", 32'(hi), 32'd32);
        check("R5 inactive clocks div16", 32'(lo), 32'd32);
    endtask

    task automatic t_invert();
        int hi, lo;
        wr(4'h1, 32'h0000_0010);
        load_ch(2, 2'd1, 5, 2);
        wr(4'h0, 32'h0000_E000);
        repeat (2) @(negedge clk);
        check("R11 inverted idle level", 32'(pwm_out[2]), 32'd1);
        wr(4'h0, 32'h0000_D000);
        measure(2, 1'b0, hi, lo);
        check("R11 active-low clocks div4", 32'(hi), 32'd12);
        check("R11 inactive-high clocks div4", 32'(lo), 32'd12);
    endtask

    task automatic t_nomatch();
        int seen;
        wr(4'h1, 32'h0);
        for (int k = 0; k < 2; k++) begin
            load_ch(3, 2'd0, 5, 5 + k);
            wr(4'h0, 32'h000A_0000);
            wr(4'h0, 32'h0009_0000);
            seen = 0;
            repeat (120) begin
                @(negedge clk);
                if (pwm_out[3]) seen++;
            end
            check($sformatf("R6 never active cmp=%0d", 5 + k), 32'(seen), 32'd0);
        end
        wr(4'h0, 32'h0);
    endtask

    task automatic t_oneshot();
        int rises, hi;
        logic prev;
        wr(4'h1, 32'h0);
        load_ch(0, 2'd0, 4, 1);
        wr(4'h0, 32'h0000_0002);
        wr(4'h0, 32'h0000_0001);
        rises = 0; hi = 0; prev = pwm_out[0];
        repeat (150) begin
            @(negedge clk);
            if (pwm_out[0]) hi++;
            if (pwm_out[0] && !prev) rises++;
            prev = pwm_out[0];
        end
        check("R9 single pulse", 32'(rises), 32'd1);
        check("R9 pulse clocks", 32'(hi), 32'd4);
        check("R9 idle after expiry", 32'(pwm_out[0]), 32'd0);
    endtask

    task automatic t_halt();
        int hi, lo, moved;
        wr(4'h1, 32'h0000_000C);
        load_ch(0, 2'd0, 9, 3);
        load_ch(1, 2'd3, 3, 1);
        wr(4'h0, 32'h0000_0A0A);
        wr(4'h0, 32'h0000_0909);
        @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        wr(4'h0, 32'h0000_0908);
        check("R7 pin high when halted", 32'(pwm_out[0]), 32'd1);
        moved = 0;
        repeat (60) begin
            @(negedge clk);
            if (!pwm_out[0]) moved++;
        end
        check("R7 halted pin holds", 32'(moved), 32'd0);
        measure(1, 1'b1, hi, lo);
        check("R7 other channel active clocks", 32'(hi), 32'd32);
        check("R7 other channel inactive clocks", 32'(lo), 32'd32);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_manual();
        int seen;
        wr(4'h1, 32'h0);
        load_ch(0, 2'd0, 2, 1);
        wr(4'h0, 32'h0000_0003);
        @(negedge clk);
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (pwm_out[0]) seen++;
        end
        check("R8 manual hold keeps pin inactive", 32'(seen), 32'd0);
        wr(4'h0, 32'h0000_0007);
        @(negedge clk);
        check("R8 manual hold inverted level", 32'(pwm_out[0]), 32'd1);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_reload();
        int hi, lo;
        wr(4'h1, 32'h0);
        load_ch(0, 2'd0, 9, 3);
        wr(4'h0, 32'h0000_000A);
        wr(4'h0, 32'h0000_0009);
        measure(0, 1'b1, hi, lo);
        check("R10 old active clocks", 32'(hi), 32'd8);
        load_ch(0, 2'd0, 7, 6);
        @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        measure(0, 1'b1, hi, lo);
        check("R10 new active clocks", 32'(hi), 32'd14);
        check("R10 new inactive clocks", 32'(lo), 32'd2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_basic();
        t_div16();
        t_invert();
        t_nomatch();
        t_oneshot();
        t_halt();
        t_manual();
        t_reload();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule